// File: doc/BRIEF.md
# Mask-Branch Single-Cycle Processor Core

This core runs one 32-bit instruction in every clock cycle. It fetches the instruction from an external instruction memory at the word address held in its program counter. The core has 32 general registers of 32 bits. Its instruction set covers five operations:

- loading a constant into a register;
- arithmetic or logic on a register and a short constant;
- arithmetic or logic on two registers;
- copying one register into another, or sending it to an addressed output port;
- an indirect jump.

The core keeps no condition flags. Compare operations write a whole-register mask: all ones when the condition holds, zero otherwise. The jump is taken only when a chosen register is all ones, so a compare followed by a jump forms a conditional branch.

The instruction memory is read combinationally: the word at `imem_addr` must be present on `imem_rdata` in the same cycle. The output port gives a one-cycle strobe with a 15-bit address and a 32-bit data word. Software uses it to place register contents on external pins.

Top module: `mbr_core`

## Requirements
- R1: While `rst` is high and after it is released, `imem_addr` is 0 and `out_valid` is 0, and every register reads as zero until it is written.
- R2: Opcode field is bits 31:27. Opcode 00000 loads bits 21:1, zero-extended, into the register named by bits 26:22 when bit 0 is set.
- R3: Every register-writing instruction writes only when its enable bit is 1. With the enable at 0, the target register keeps its old value.
- R4: Opcode 00001 combines the register at bits 26:22 with the 13-bit constant at bits 18:6, zero-extended, and writes the result back to that register. Function is in bits 21:19, condition in bits 5:3, invert in bit 2, carry/borrow in bit 1 and enable in bit 0.
- R5: Function codes: 000 is add plus carry-in and 001 is subtract minus borrow-in, both modulo 2^32. 011 is a left shift and 100 is a logical right shift, each by the low 5 bits of the right operand. 101 is AND, 110 is OR and 111 is XOR.
- R6: Function 010 writes all ones when the condition holds and zero otherwise. Condition codes: 000 is left below right (unsigned), 001 is left above right, 010 is equal, 011 is left operand zero and 100 is always. 101 to 111 never hold. The invert bit negates the outcome.
- R7: Opcode 00011 uses the register at bits 26:22 as left operand and the register at bits 18:14 as right operand, and writes the result to the left register. Function is in bits 21:19, carry/borrow in bit 13, enable in bit 12, condition in bits 11:9 and invert in bit 8.
- R8: Opcode 00010 has source at bits 26:22, destination at bits 21:17, enable at bit 16 and switch at bits 15:1. With switch 0 it copies source to destination when enabled, and it never raises `out_valid`.
- R9: Opcode 00010 with a nonzero switch writes no register. In the next cycle it raises `out_valid` for one cycle, with `out_addr` equal to the switch and `out_data` equal to the source register.
- R10: Opcode 00100 sets the program counter to the low address bits of the register at bits 21:17 when the register at bits 26:22 is all ones. Otherwise it advances the program counter by one.
- R11: Every instruction other than a taken jump advances the program counter by one, wrapping modulo 2^AW.
- R12: Opcodes 00101 to 11111 write no register, raise no output strobe, and advance the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW (10) | Word address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| out_valid | output | 1 | One-cycle strobe for an output store |
| out_addr | output | 15 | Output address taken from the switch field |
| out_data | output | 32 | Value of the source register |

## Verification
The registers can only be seen through output stores and taken jumps. A corrupted register therefore stays hidden until an output store reads it, or a jump uses it as condition or target. A store shows the bad value one cycle later on `out_data`. A jump shows it on `imem_addr` after the next edge. A wrong program counter shows on `imem_addr` at the very next cycle.

The bench keeps a model of the instruction set in lockstep with the core. It compares `imem_addr` every cycle and checks the output port after every instruction. A fault is therefore reported on the first cycle it reaches a pin, tagged with the instruction class that last wrote the value involved.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int RSEL_W = 5;
  localparam int LIT_W  = 21;
  localparam int SIMM_W = 13;
  localparam int PORT_W = 15;

  typedef enum logic [4:0] {
    OPC_LDI  = 5'd0,
    OPC_ALUI = 5'd1,
    OPC_MOVE = 5'd2,
    OPC_ALUR = 5'd3,
    OPC_JMSK = 5'd4
  } opc_e;

  typedef enum logic [2:0] {
    F_ADD = 3'd0, F_SUB = 3'd1, F_CMP = 3'd2, F_SHL = 3'd3,
    F_SHR = 3'd4, F_AND = 3'd5, F_OR  = 3'd6, F_XOR = 3'd7
  } fn_e;

  typedef enum logic [1:0] {WS_LIT, WS_ALU, WS_REG} wsrc_e;

  typedef struct packed {
    fn_e        fn;
    logic [2:0] cond;
    logic       neg;
    logic       cin;
  } alu_ctl_t;

  typedef struct packed {
    logic [RSEL_W-1:0] ra;
    logic [RSEL_W-1:0] rb;
    logic [RSEL_W-1:0] wa;
    logic              we;
    wsrc_e             wsrc;
    logic              b_lit;
    logic [SIMM_W-1:0] simm;
    logic [LIT_W-1:0]  lit;
    alu_ctl_t          ctl;
    logic              out_fire;
    logic [PORT_W-1:0] port;
    logic              jump;
  } dec_t;
endpackage

// File: rtl/mbr_decode.sv
module mbr_decode
  import mbr_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  opc_e opc;
  assign opc = opc_e'(instr[31:27]);

  always_comb begin
    dec          = '0;
    dec.ra       = instr[26:22];
    dec.rb       = (opc == OPC_ALUR) ? instr[18:14] : instr[21:17];
    dec.wa       = instr[26:22];
    dec.simm     = instr[18:6];
    dec.lit      = instr[21:1];
    dec.port     = instr[15:1];
    dec.wsrc     = WS_ALU;
    dec.ctl.fn   = fn_e'(instr[21:19]);
    case (opc)
      OPC_LDI: begin
        dec.wsrc = WS_LIT;
        dec.we   = instr[0];
      end
      OPC_ALUI: begin
        dec.b_lit    = 1'b1;
        dec.ctl.cond = instr[5:3];
        dec.ctl.neg  = instr[2];
        dec.ctl.cin  = instr[1];
        dec.we       = instr[0];
      end
      OPC_MOVE: begin
        dec.wsrc     = WS_REG;
        dec.wa       = instr[21:17];
        dec.out_fire = (instr[15:1] != '0);
        dec.we       = instr[16] && (instr[15:1] == '0);
      end
      OPC_ALUR: begin
        dec.ctl.cin  = instr[13];
        dec.we       = instr[12];
        dec.ctl.cond = instr[11:9];
        dec.ctl.neg  = instr[8];
      end
      OPC_JMSK: dec.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mbr_alu.sv
module mbr_alu
  import mbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctl_t     ctl,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);

  logic            hit;
  logic            met;
  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (ctl.cond)
      3'd0:    hit = (a < b);
      3'd1:    hit = (a > b);
      3'd2:    hit = (a == b);
      3'd3:    hit = (a == '0);
      3'd4:    hit = 1'b1;
      default: hit = 1'b0;
    endcase
    met = hit ^ ctl.neg;
  end

  always_comb begin
    case (ctl.fn)
      F_ADD:   y = a + b + W'(ctl.cin);
      F_SUB:   y = a - b - W'(ctl.cin);
      F_CMP:   y = met ? '1 : '0;
      F_SHL:   y = a << sh;
      F_SHR:   y = a >> sh;
      F_AND:   y = a & b;
      F_OR:    y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/mbr_regfile.sv
module mbr_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int A = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [A-1:0] wa,
  input  logic [W-1:0] wd,
  input  logic [A-1:0] ra_a,
  input  logic [A-1:0] ra_b,
  output logic [W-1:0] rd_a,
  output logic [W-1:0] rd_b
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/mbr_core.sv
module mbr_core
  import mbr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [AW-1:0]     imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_addr,
  output logic [XLEN-1:0]   out_data
);
  localparam int NREG = 1 << RSEL_W;

  dec_t            dec;
  logic [AW-1:0]   pc;
  logic [AW-1:0]   pc_next;
  logic [XLEN-1:0] a_data;
  logic [XLEN-1:0] b_data;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic [XLEN-1:0] wr_data;

  mbr_decode u_dec (.instr(imem_rdata), .dec(dec));

  mbr_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (dec.we),
    .wa  (dec.wa),
    .wd  (wr_data),
    .ra_a(dec.ra),
    .ra_b(dec.rb),
    .rd_a(a_data),
    .rd_b(b_data)
  );

  assign alu_b = dec.b_lit ? XLEN'(dec.simm) : b_data;

  mbr_alu #(.W(XLEN)) u_alu (.a(a_data), .b(alu_b), .ctl(dec.ctl), .y(alu_y));

  always_comb begin
    case (dec.wsrc)
      WS_LIT:  wr_data = XLEN'(dec.lit);
      WS_REG:  wr_data = a_data;
      default: wr_data = alu_y;
    endcase
  end

  assign pc_next = (dec.jump && (&a_data)) ? b_data[AW-1:0] : pc + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      pc        <= pc_next;
      out_valid <= dec.out_fire;
      if (dec.out_fire) begin
        out_addr <= dec.port;
        out_data <= a_data;
      end
    end
  end

  assign imem_addr = pc;
endmodule

// File: rtl/mbr_core_chk.sv
module mbr_core_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   imem_addr,
  input logic [31:0]     imem_rdata,
  input logic            out_valid,
  input logic [14:0]     out_addr,
  input logic [XLEN-1:0] a_data,
  input logic [XLEN-1:0] b_data
);
  logic [4:0] opc;
  logic       is_out;
  assign opc    = imem_rdata[31:27];
  assign is_out = (opc == 5'd2) && (imem_rdata[15:1] != 15'd0);

  p_pc_reset_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0) && !out_valid);

  p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
    (opc != 5'd4) |=> imem_addr == $past(imem_addr) + AW'(1));

  p_jump_taken_r10: assert property (@(posedge clk) disable iff (rst)
    ((opc == 5'd4) && (&a_data)) |=> imem_addr == $past(b_data[AW-1:0]));

  p_jump_fall_r10: assert property (@(posedge clk) disable iff (rst)
    ((opc == 5'd4) && !(&a_data)) |=> imem_addr == $past(imem_addr) + AW'(1));

  p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    is_out |=> out_valid && (out_addr == $past(imem_rdata[15:1])));

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !is_out |=> !out_valid);

  p_unknown_r12: assert property (@(posedge clk) disable iff (rst)
    (opc > 5'd4) |=> !out_valid);
endmodule

bind mbr_core mbr_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_rdata(imem_rdata),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .a_data    (a_data),
  .b_data    (b_data)
);

// File: tb/mbr_core_tb.sv
module mbr_core_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        out_valid;
  logic [14:0] out_addr;
  logic [31:0] out_data;

  logic [31:0] prog [DEPTH];
  assign imem_rdata = prog[imem_addr];

  mbr_core #(.XLEN(32), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // reference state
  logic [31:0]   mr [32];
  string         wt [32];
  logic [AW-1:0] mpc;
  logic          e_ov;
  logic [14:0]   e_oa;
  logic [31:0]   e_od;
  string         e_dtag;
  string         q_tag;
  string         p_tag;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle pc %0d)", tag, act, exp, mpc);
    end
  endtask

  function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
      input logic [2:0] fn, input logic [2:0] cnd, input logic ng, input logic ci);
    logic h;
    case (cnd)
      3'd0: h = a < b;
      3'd1: h = a > b;
      3'd2: h = a == b;
      3'd3: h = a == 32'd0;
      3'd4: h = 1'b1;
      default: h = 1'b0;
    endcase
    case (fn)
      3'd0: return a + b + {31'd0, ci};
      3'd1: return a - b - {31'd0, ci};
      3'd2: return (h ^ ng) ? 32'hFFFF_FFFF : 32'd0;
      3'd3: return a << b[4:0];
      3'd4: return a >> b[4:0];
      3'd5: return a & b;
      3'd6: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [31:0] enc_ldi(input int rd, input logic [20:0] v, input logic we);
    return {5'd0, 5'(rd), v, we};
  endfunction
  function automatic logic [31:0] enc_alui(input int r, input logic [2:0] fn, input logic [12:0] v,
      input logic [2:0] cnd, input logic ng, input logic ci, input logic we);
    return {5'd1, 5'(r), fn, v, cnd, ng, ci, we};
  endfunction
  function automatic logic [31:0] enc_move(input int rs, input int rd, input logic we, input logic [14:0] sw);
    return {5'd2, 5'(rs), 5'(rd), we, sw, 1'b0};
  endfunction
  function automatic logic [31:0] enc_alur(input int ra, input logic [2:0] fn, input int rb,
      input logic ci, input logic we, input logic [2:0] cnd, input logic ng);
    return {5'd3, 5'(ra), fn, 5'(rb), ci, we, cnd, ng, 8'd0};
  endfunction
  function automatic logic [31:0] enc_jmp(input int rc, input int rl);
    return {5'd4, 5'(rc), 5'(rl), 17'd0};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin mr[i] = 32'd0; wt[i] = "R1"; end
    mpc = '0; e_ov = 1'b0; e_oa = '0; e_od = '0; e_dtag = "R1"; q_tag = "R1"; p_tag = "R1";
  endtask

  task automatic model_step();
    logic [31:0] ins, v;
    logic [4:0]  op, r1, r2;
    ins = prog[mpc];
    op = ins[31:27]; r1 = ins[26:22]; r2 = ins[21:17];
    e_ov = 1'b0; p_tag = "R11"; q_tag = "R9";
    case (op)
      5'd0: begin
        if (ins[0]) begin mr[r1] = {11'd0, ins[21:1]}; wt[r1] = "R2"; end
        else wt[r1] = "R3";
      end
      5'd1: begin
        v = ref_alu(mr[r1], {19'd0, ins[18:6]}, ins[21:19], ins[5:3], ins[2], ins[1]);
        if (ins[0]) begin mr[r1] = v; wt[r1] = (ins[21:19] == 3'd2) ? "R4/R6" : "R4/R5"; end
        else wt[r1] = "R3";
      end
      5'd2: begin
        if (ins[15:1] != 15'd0) begin
          e_ov = 1'b1; e_oa = ins[15:1]; e_od = mr[r1]; e_dtag = wt[r1];
        end else begin
          q_tag = "R8";
          if (ins[16]) begin mr[r2] = mr[r1]; wt[r2] = "R8"; end
          else wt[r2] = "R3";
        end
      end
      5'd3: begin
        v = ref_alu(mr[r1], mr[ins[18:14]], ins[21:19], ins[11:9], ins[8], ins[13]);
        if (ins[12]) begin mr[r1] = v; wt[r1] = (ins[21:19] == 3'd2) ? "R7/R6" : "R7/R5"; end
        else wt[r1] = "R3";
      end
      5'd4: p_tag = "R10";
      default: begin p_tag = "R12"; q_tag = "R12"; end
    endcase
    if (op == 5'd4 && mr[r1] == 32'hFFFF_FFFF) mpc = mr[r2][AW-1:0];
    else mpc = mpc + AW'(1);
  endtask

  task automatic run(input int cycles);
    rst = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == '0, "R1 reset pc", 32'(imem_addr), 32'd0);
    chk(out_valid == 1'b0, "R1 reset strobe", 32'(out_valid), 32'd0);
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      chk(imem_addr == mpc, {p_tag, " pc"}, 32'(imem_addr), 32'(mpc));
      chk(out_valid == e_ov, {q_tag, " strobe"}, 32'(out_valid), 32'(e_ov));
      if (e_ov) begin
        chk(out_addr == e_oa, "R9 addr", 32'(out_addr), 32'(e_oa));
        chk(out_data == e_od, {e_dtag, " data"}, out_data, e_od);
      end
      model_step();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // directed program
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'd0;
    prog[0]  = enc_move(9, 0, 1'b0, 15'd5);                 // R1 untouched reg
    prog[1]  = enc_ldi(1, 21'h1FFFFF, 1'b1);                // R2 max literal
    prog[2]  = enc_ldi(2, 21'd5, 1'b0);                     // R3 disabled write
    prog[3]  = enc_move(1, 0, 1'b0, 15'h7FFF);              // R9 top address
    prog[4]  = enc_move(2, 0, 1'b0, 15'd1);
    prog[5]  = enc_alui(1, 3'd0, 13'h1FFF, 3'd0, 1'b0, 1'b1, 1'b1); // R4/R5 add+carry
    prog[6]  = enc_move(1, 0, 1'b0, 15'd2);
    prog[7]  = enc_alui(3, 3'd1, 13'd1, 3'd0, 1'b0, 1'b1, 1'b1);    // R5 borrow wrap
    prog[8]  = enc_move(3, 0, 1'b0, 15'd3);
    prog[9]  = enc_alui(4, 3'd2, 13'd0, 3'd4, 1'b0, 1'b0, 1'b1);    // R6 always
    prog[10] = enc_ldi(5, 21'd30, 1'b1);
    prog[11] = enc_jmp(4, 5);                               // R10 taken
    for (int i = 12; i < 30; i++) prog[i] = 32'hFFFF_FFFF;
    prog[30] = enc_move(4, 0, 1'b0, 15'd4);
    prog[31] = enc_jmp(1, 5);                               // R10 not taken
    prog[32] = 32'hF800_0001;                               // R12 unknown
    prog[33] = enc_ldi(7, 21'd35, 1'b1);
    prog[34] = enc_alur(1, 3'd3, 7, 1'b0, 1'b1, 3'd0, 1'b0); // R7 shift by 3
    prog[35] = enc_move(1, 8, 1'b1, 15'd0);                 // R8 copy
    prog[36] = enc_move(8, 0, 1'b0, 15'd6);
    prog[37] = enc_alur(3, 3'd2, 1, 1'b0, 1'b1, 3'd1, 1'b0); // R6 above
    prog[38] = enc_alur(1, 3'd2, 3, 1'b0, 1'b1, 3'd0, 1'b1); // R6 not below
    prog[39] = enc_move(3, 0, 1'b0, 15'd7);
    prog[40] = enc_move(1, 0, 1'b0, 15'd8);
    prog[41] = enc_alur(3, 3'd7, 3, 1'b0, 1'b0, 3'd0, 1'b0); // R3 disabled alu
    prog[42] = enc_move(3, 0, 1'b0, 15'd9);
    run(60);
    // constrained random program
    for (int i = 0; i < DEPTH; i++) begin
      int k;
      k = int'($urandom % 8);
      case (k)
        0: prog[i] = enc_ldi(int'($urandom % 32), 21'($urandom), ($urandom % 8) != 0);
        1, 2: prog[i] = enc_alui(int'($urandom % 32), 3'($urandom), 13'($urandom), 3'($urandom),
                                 1'($urandom), 1'($urandom), ($urandom % 8) != 0);
        3: prog[i] = enc_move(int'($urandom % 32), int'($urandom % 32), 1'($urandom), 15'd0);
        4: prog[i] = enc_move(int'($urandom % 32), 0, 1'b0, 15'($urandom % 32767 + 1));
        5: prog[i] = enc_alur(int'($urandom % 32), 3'($urandom), int'($urandom % 32), 1'($urandom),
                              ($urandom % 8) != 0, 3'($urandom), 1'($urandom));
        6: prog[i] = enc_jmp(int'($urandom % 32), int'($urandom % 32));
        default: prog[i] = {5'(5 + $urandom % 27), 27'($urandom)};
      endcase
    end
    run(4000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule